// File: doc/BRIEF.md
# Console Character Emitter

This block serves the console output service calls of a small 16-bit processor core. The core hands it a one-byte service vector and the contents of its first general register. The block then sends characters, one per handshake, to a downstream console or serial transmitter over a valid/ready byte stream. Some services fetch characters from memory. For those, the block reads 16-bit words from a word-addressed memory port whose read data returns one cycle after the request.

Four services are recognised: output of a single character, output of a string stored one character per word, output of a string packed two characters per word, and halt. The halt service prints a fixed four-letter word and then signals the core to stop. Any other vector finishes at once and produces nothing. The requester learns that a service has finished from a one-cycle done pulse.

Top module: `con_emit_top`

## Requirements
- R1: A request is taken only when `busy` is low. `busy` is high from the cycle after acceptance until the service finishes. `req_start` pulses while `busy` is high are ignored. Each accepted request gives exactly one single-cycle `done` pulse, and `busy` is low once the done pulse has passed.
- R2: Vector 0x21 sends exactly one character, equal to bits [7:0] of `req_r0`, and issues no memory read.
- R3: Vector 0x22 reads words at increasing addresses, starting at `req_r0`. For each word it sends bits [7:0] as one character, and bits [15:8] have no effect.
- R4: In both string services, a word equal to 0x0000 ends the string. The terminator is never sent, and no word after it is read.
- R5: Vector 0x24 sends bits [7:0] of each word first and then bits [15:8].
- R6: In the packed service, a high byte of 0x00 is not sent, and scanning continues with the next word.
- R7: Vector 0x25 sends 0x48, 0x41, 0x4C, 0x54 in that order and issues no memory read. `halt` pulses in the same cycle as `done`, and only for this vector.
- R8: Any other vector issues no memory read and sends nothing. `done` rises the cycle after acceptance.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. No memory read is issued while a character is pending, so no character is lost or reordered under backpressure.
- R10: The read address wraps from 0xFFFF to 0x0000 when a string runs past the top of memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Request pulse, taken when idle |
| req_vec | input | 8 | Service vector |
| req_r0 | input | 16 | Character or string start address |
| busy | output | 1 | A service is in progress |
| done | output | 1 | Single-cycle completion pulse |
| halt | output | 1 | Halt pulse to the core, with done |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Word address of the read |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| tx_valid | output | 1 | A character is offered |
| tx_data | output | 8 | Character value |
| tx_ready | input | 1 | Transmitter accepts the character |

## Verification
The single-character and halt services offer their first character in the cycle after the accepting edge. A memory-fed character appears two cycles after its read is requested: one cycle for the read and one for the capture. After the last handshake, or after the terminator is captured, `done` follows one cycle later; for an unknown vector it follows the accepting edge directly. The bench does not tie characters to fixed cycles. Each falling edge first sets a new random `tx_ready` level and then records a handshake only where valid and ready are both high, so the rising edge that completes the transfer is the one being recorded. `done`, `halt` and read requests are counted on the same falling edges, and after the done pulse the collected stream and counts are compared with values derived from a bench model of the memory.

// File: rtl/con_emit_pkg.sv
package con_emit_pkg;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 16;
  localparam int CHAR_W = 8;
  localparam int VEC_W  = 8;
  localparam int HALT_N = 4;

  localparam logic [VEC_W-1:0] VEC_ONE  = 8'h21;
  localparam logic [VEC_W-1:0] VEC_WIDE = 8'h22;
  localparam logic [VEC_W-1:0] VEC_PACK = 8'h24;
  localparam logic [VEC_W-1:0] VEC_STOP = 8'h25;

  typedef enum logic [2:0] {K_NONE, K_ONE, K_WIDE, K_PACK, K_STOP} svc_t;
  typedef enum logic [2:0] {S_IDLE, S_READ, S_CAPT, S_SEND, S_FIN} phase_t;

  // Map a raw vector onto the service it selects.
  function automatic svc_t svc_of(input logic [VEC_W-1:0] v);
    case (v)
      VEC_ONE:  return K_ONE;
      VEC_WIDE: return K_WIDE;
      VEC_PACK: return K_PACK;
      VEC_STOP: return K_STOP;
      default:  return K_NONE;
    endcase
  endfunction

  // Letters printed by the stop service, by position.
  function automatic logic [CHAR_W-1:0] stop_glyph(input int unsigned i);
    case (i)
      0:       return 8'h48;
      1:       return 8'h41;
      2:       return 8'h4C;
      default: return 8'h54;
    endcase
  endfunction

  // Byte lane of a word: lane 0 is the low byte.
  function automatic logic [CHAR_W-1:0] lane_of(input logic [WORD_W-1:0] w, input logic hi);
    return hi ? w[WORD_W-1 -: CHAR_W] : w[CHAR_W-1:0];
  endfunction
endpackage

// File: rtl/con_emit_addr.sv
module con_emit_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr == {AW{1'b1}}) |=> (ptr == '0)); // R10
endmodule

// File: rtl/con_emit_char.sv
module con_emit_char
  import con_emit_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_mem,
  input  logic              cap_r0,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [WORD_W-1:0] r0_word,
  input  logic              sel_hi,
  input  logic              glyph_mode,
  input  logic [IW-1:0]     glyph_idx,
  output logic              in_zero,
  output logic              hi_zero,
  output logic [CHAR_W-1:0] char_out
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (cap_r0)  word_q <= r0_word;
    else if (cap_mem) word_q <= mem_word;
  end

  assign in_zero  = (mem_word == '0);
  assign hi_zero  = (lane_of(word_q, 1'b1) == '0);
  assign char_out = glyph_mode ? stop_glyph(int'(glyph_idx)) : lane_of(word_q, sel_hi);
endmodule

// File: rtl/con_emit_ctrl.sv
module con_emit_ctrl
  import con_emit_pkg::*;
#(
  parameter int N_GLYPH = HALT_N,
  localparam int IW = (N_GLYPH > 1) ? $clog2(N_GLYPH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             in_zero,
  input  logic             hi_zero,
  input  logic             tx_ready,
  output logic             busy,
  output logic             done,
  output logic             halt,
  output logic             mem_rd_en,
  output logic             tx_valid,
  output logic             ptr_load,
  output logic             ptr_step,
  output logic             cap_mem,
  output logic             cap_r0,
  output logic             sel_hi,
  output logic             glyph_mode,
  output logic [IW-1:0]    glyph_idx
);
  phase_t phase;
  svc_t   svc_q;
  svc_t   svc_in;
  logic   accept;
  logic   tx_fire;
  logic   last_glyph;
  logic   to_high;

  assign svc_in     = svc_of(req_vec);
  assign accept     = (phase == S_IDLE) && req_start;
  assign tx_fire    = (phase == S_SEND) && tx_ready;
  assign last_glyph = (glyph_idx == IW'(N_GLYPH - 1));
  assign to_high    = (svc_q == K_PACK) && !sel_hi && !hi_zero;

  assign busy       = (phase != S_IDLE);
  assign done       = (phase == S_FIN);
  assign halt       = (phase == S_FIN) && (svc_q == K_STOP);
  assign mem_rd_en  = (phase == S_READ);
  assign tx_valid   = (phase == S_SEND);
  assign glyph_mode = (svc_q == K_STOP);
  assign ptr_load   = accept && (svc_in == K_WIDE || svc_in == K_PACK);
  assign cap_r0     = accept && (svc_in == K_ONE);
  assign cap_mem    = (phase == S_CAPT) && !in_zero;
  assign ptr_step   = tx_fire && ((svc_q == K_WIDE) || ((svc_q == K_PACK) && !to_high));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      svc_q     <= K_NONE;
      sel_hi    <= 1'b0;
      glyph_idx <= '0;
    end else begin
      case (phase)
        S_IDLE: if (req_start) begin
          svc_q     <= svc_in;
          sel_hi    <= 1'b0;
          glyph_idx <= '0;
          case (svc_in)
            K_ONE, K_STOP:  phase <= S_SEND;
            K_WIDE, K_PACK: phase <= S_READ;
            default:        phase <= S_FIN;
          endcase
        end
        S_READ: phase <= S_CAPT;
        S_CAPT: begin
          sel_hi <= 1'b0;
          phase  <= in_zero ? S_FIN : S_SEND;
        end
        S_SEND: if (tx_ready) begin
          case (svc_q)
            K_STOP: if (last_glyph) phase <= S_FIN;
                    else glyph_idx <= glyph_idx + 1'b1;
            K_WIDE: phase <= S_READ;
            K_PACK: if (to_high) sel_hi <= 1'b1;
                    else phase <= S_READ;
            default: phase <= S_FIN;
          endcase
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_HALT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> done); // R7
  AST_HIGH_LANE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_hi) |-> !hi_zero); // R6
  AST_NO_READ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !tx_valid); // R9
  AST_UNKNOWN_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_start && svc_of(req_vec) == K_NONE) |=> (done && !tx_valid)); // R8
endmodule

// File: rtl/con_emit_top.sv
module con_emit_top
  import con_emit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic [WORD_W-1:0] req_r0,
  output logic              busy,
  output logic              done,
  output logic              halt,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              tx_ready
);
  localparam int IW = (HALT_N > 1) ? $clog2(HALT_N) : 1;

  logic          ptr_load, ptr_step, cap_mem, cap_r0;
  logic          sel_hi, glyph_mode, in_zero, hi_zero;
  logic [IW-1:0] glyph_idx;

  con_emit_ctrl #(.N_GLYPH(HALT_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_vec(req_vec),
    .in_zero(in_zero), .hi_zero(hi_zero), .tx_ready(tx_ready),
    .busy(busy), .done(done), .halt(halt), .mem_rd_en(mem_rd_en),
    .tx_valid(tx_valid), .ptr_load(ptr_load), .ptr_step(ptr_step),
    .cap_mem(cap_mem), .cap_r0(cap_r0), .sel_hi(sel_hi),
    .glyph_mode(glyph_mode), .glyph_idx(glyph_idx)
  );

  con_emit_addr #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(req_r0[ADDR_W-1:0]),
    .step(ptr_step), .ptr(mem_rd_addr)
  );

  con_emit_char #(.IW(IW)) u_char (
    .clk(clk), .rst_n(rst_n), .cap_mem(cap_mem), .cap_r0(cap_r0),
    .mem_word(mem_rd_data), .r0_word(req_r0), .sel_hi(sel_hi),
    .glyph_mode(glyph_mode), .glyph_idx(glyph_idx),
    .in_zero(in_zero), .hi_zero(hi_zero), .char_out(tx_data)
  );

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R9
endmodule

// File: tb/sim_con_emit_top.sv
`timescale 1ns/1ps
module sim_con_emit_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [7:0]  req_vec = '0;
  logic [15:0] req_r0 = '0;
  logic        busy, done, halt, mem_rd_en, tx_valid, tx_ready = 1'b0;
  logic [15:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic [7:0]  tx_data;

  int checks = 0, failures = 0;
  int done_cnt = 0, halt_cnt = 0, rd_cnt = 0, rdy_pct = 100;
  logic [15:0] mem [logic [15:0]];
  logic [7:0]  exp_q[$];
  logic [7:0]  got_q[$];

  always #2 clk = ~clk;

  con_emit_top u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_vec(req_vec), .req_r0(req_r0),
    .busy(busy), .done(done), .halt(halt), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  function automatic logic [15:0] mrd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mrd(mem_rd_addr);

  // Set ready first, then record what the next rising edge will transfer.
  always @(negedge clk) begin
    tx_ready = ($urandom % 100) < rdy_pct;
    if (tx_valid && tx_ready) got_q.push_back(tx_data);
    if (done) done_cnt++;
    if (halt) halt_cnt++;
    if (mem_rd_en) rd_cnt++;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] v);
    case (v)
      8'h21: return "R2";
      8'h22: return "R3";
      8'h24: return "R5";
      8'h25: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic build_expect(input logic [7:0] v, input logic [15:0] r0);
    logic [15:0] a = r0;
    exp_q.delete();
    case (v)
      8'h21: exp_q.push_back(r0[7:0]);
      8'h25: begin
        exp_q.push_back(8'h48); exp_q.push_back(8'h41);
        exp_q.push_back(8'h4C); exp_q.push_back(8'h54);
      end
      8'h22, 8'h24: for (int n = 0; n < 300; n++) begin
        logic [15:0] w = mrd(a);
        if (w == 16'h0000) break;
        exp_q.push_back(w[7:0]);
        if (v == 8'h24 && w[15:8] != 8'h00) exp_q.push_back(w[15:8]);
        a = a + 16'd1;
      end
      default: ;
    endcase
  endtask

  task automatic put_string(input logic [15:0] base, input int len, input bit packed_mode);
    logic [15:0] a = base;
    for (int i = 0; i < len; i++) begin
      logic [7:0] lo = 8'(1 + $urandom % 255);
      logic [7:0] hi;
      if (packed_mode) hi = ($urandom % 4 == 0) ? 8'h00 : 8'(1 + $urandom % 255);
      else hi = 8'($urandom);
      mem[a] = {hi, lo};
      a = a + 16'd1;
    end
    mem[a] = 16'h0000;
    mem[a + 16'd1] = 16'h7E7E;
  endtask

  task automatic run_op(input logic [7:0] v, input logic [15:0] r0, input int pct,
                        input bit poke, input string xtag);
    int n = 0;
    bit same = 1;
    build_expect(v, r0);
    rdy_pct = pct;
    @(negedge clk);
    got_q.delete(); done_cnt = 0; halt_cnt = 0; rd_cnt = 0;
    req_vec = v; req_r0 = r0; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_vec = 8'h21; req_r0 = 16'h005A; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (done_cnt == 0 && n < 5000) begin @(posedge clk); n++; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done count", done_cnt == 1, done_cnt, 1);
    chk("R1 busy after done", busy == 1'b0, busy, 0);
    chk((v == 8'h22 || v == 8'h24) ? "R4 length" : {tag_of(v), " length"},
        got_q.size() == exp_q.size(), got_q.size(), exp_q.size());
    foreach (exp_q[i]) if (i >= got_q.size() || got_q[i] !== exp_q[i]) same = 0;
    chk({tag_of(v), " characters"}, same, got_q.size() > 0 ? got_q[0] : 0,
        exp_q.size() > 0 ? exp_q[0] : 0);
    if (xtag.len() > 0) chk({xtag, " characters"}, same, got_q.size(), exp_q.size());
    chk("R7 halt count", halt_cnt == (v == 8'h25 ? 1 : 0), halt_cnt, v == 8'h25 ? 1 : 0);
    if (v != 8'h22 && v != 8'h24) chk({tag_of(v), " no read"}, rd_cnt == 0, rd_cnt, 0);
    else chk("R4 reads stop at terminator", rd_cnt == exp_words(v, r0), rd_cnt, exp_words(v, r0));
  endtask

  function automatic int exp_words(input logic [7:0] v, input logic [15:0] r0);
    logic [15:0] a = r0;
    int k = 1;
    if (v != 8'h22 && v != 8'h24) return 0;
    while (mrd(a) != 16'h0000 && k < 300) begin a = a + 16'd1; k++; end
    return k;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy == 1'b0, busy, 0);
    chk("R1 reset done", done == 1'b0, done, 0);
    chk("R9 reset tx_valid", tx_valid == 1'b0, tx_valid, 0);
    chk("R7 reset halt", halt == 1'b0, halt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: single character, high byte of R0 ignored
    run_op(8'h21, 16'hC341, 100, 0, "");
    // R3: wide string, high bytes ignored
    mem.delete(); put_string(16'h3000, 5, 0);
    run_op(8'h22, 16'h3000, 100, 0, "");
    // R4: empty string sends nothing
    mem.delete(); mem[16'h4000] = 16'h0000; mem[16'h4001] = 16'h4141;
    run_op(8'h22, 16'h4000, 100, 0, "R4");
    run_op(8'h24, 16'h4000, 100, 0, "");
    // R5/R6: packed with zero high bytes in the middle
    mem.delete();
    mem[16'h5000] = 16'h4241; mem[16'h5001] = 16'h0043;
    mem[16'h5002] = 16'h4544; mem[16'h5003] = 16'h0000;
    run_op(8'h24, 16'h5000, 100, 0, "R6");
    // R10: string across the top of memory
    mem.delete(); put_string(16'hFFFD, 6, 0);
    run_op(8'h22, 16'hFFFD, 70, 0, "R10");
    mem.delete(); put_string(16'hFFFE, 4, 1);
    run_op(8'h24, 16'hFFFE, 70, 0, "R10");
    // R7: halt under backpressure
    run_op(8'h25, 16'h1234, 40, 0, "");
    // R8: unknown vector
    run_op(8'h23, 16'h0041, 100, 0, "");
    // R9: heavy backpressure
    mem.delete(); put_string(16'h0100, 8, 1);
    run_op(8'h24, 16'h0100, 15, 0, "R9");
    // R1: second request while busy is ignored
    mem.delete(); put_string(16'h0200, 10, 0);
    run_op(8'h22, 16'h0200, 10, 1, "R1");

    for (int it = 0; it < 40; it++) begin
      logic [7:0]  v;
      logic [15:0] r0 = 16'($urandom);
      int sel = $urandom % 5;
      case (sel)
        0: v = 8'h21;
        1: v = 8'h22;
        2: v = 8'h24;
        3: v = 8'h25;
        default: begin
          v = 8'($urandom);
          if (v inside {8'h21, 8'h22, 8'h24, 8'h25}) v = 8'h30;
        end
      endcase
      mem.delete();
      if (v == 8'h22 || v == 8'h24) put_string(r0, $urandom % 13, v == 8'h24);
      run_op(v, r0, 30 + $urandom % 71, 0, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule